// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped, using only its 48-bit destination address. The receive path hands it the six address octets one at a time, first octet on the wire first. It marks the start of each frame with a one-cycle strobe. While the octets arrive, the block does three jobs in parallel. It compares each octet with the programmed station address. It tracks whether the address is all ones. It folds the octets into a running CRC-32, and the top six bits of that CRC pick one bin of a 64-bin multicast hash table.

When the sixth octet is taken, the block registers a verdict. The verdict stays valid until the next start strobe. Octets that arrive after the sixth are ignored, and so are configuration changes made after the verdict. Three mode inputs change the policy: promiscuous acceptance, rejection of broadcast, and a hash lookup for unicast addresses that miss the station address.

Top module: `dst_addr_screen`

## Requirements
- R1: After reset, `decision_valid` and `accept` are both 0.
- R2: An octet counts only in a cycle where `byte_valid` is 1. `decision_valid` becomes 1 on the clock edge that takes the sixth counted octet and not before, so gaps of any length between octets are allowed.
- R3: `frame_start` discards any partial address and clears `decision_valid` on the next edge. An octet presented in the same cycle as `frame_start` counts as octet 0. Octets received before the first start strobe after reset are ignored.
- R4: The station address is laid out with octet 0 in `station_hi[15:8]`, octet 1 in `station_hi[7:0]`, and octets 2 to 5 in `station_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. A unicast address equal to the station address is accepted.
- R5: The broadcast address (all six octets 0xFF) is accepted when `cfg_bcast_reject` is 0 and rejected when it is 1.
- R6: A multicast address (bit 0 of octet 0 set, and not broadcast) is accepted only if its hash bit is 1. The hash index is bits 31:26 of a CRC-32 run over the six octets. The CRC uses polynomial 0x04C11DB7, starts at 0xFFFFFFFF, takes each octet LSB first, and has no final inversion. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0); index bits 4:0 select the bit within that word.
- R7: A unicast address that differs from the station address is rejected, unless `cfg_hash_unicast` is 1 and its hash bit (as in R6) is 1.
- R8: With `cfg_promisc` at 1, every address is accepted, including broadcast while `cfg_bcast_reject` is 1.
- R9: Once valid, the verdict holds until the next `frame_start`. Extra octets and changes to any configuration input after the sixth octet do not change it.
- R10: `accept` is 1 only while `decision_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe that begins a new destination address |
| byte_valid | input | 1 | `byte_data` holds an address octet this cycle |
| byte_data | input | 8 | Address octet, first octet on the wire first |
| station_lo | input | 32 | Station address octets 2..5 |
| station_hi | input | 16 | Station address octets 0..1 |
| hash_lo | input | 32 | Multicast hash bins 0..31 |
| hash_hi | input | 32 | Multicast hash bins 32..63 |
| cfg_promisc | input | 1 | Accept every address |
| cfg_bcast_reject | input | 1 | Reject the broadcast address |
| cfg_hash_unicast | input | 1 | Also look up unmatched unicast addresses in the hash table |
| decision_valid | output | 1 | Verdict for the current address is available |
| accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
For every hash test, the bench programs either only the bin its own CRC predicts, or every bin except that one. A design with the wrong bit order, seed or index slice then reads the wrong bin and flips the verdict. Addresses that differ from the station address in a single octet, or in the multicast bit alone, catch a comparator that looks at the wrong lane or lets a unicast match override the multicast rule. Gapped octets, strobes arriving mid-address and octets sent before any strobe expose a counter that counts idle cycles, keeps stale partial state, or starts without a strobe. Extra octets and changes to the configuration after the verdict show whether the decision register is really held.

// File: rtl/dst_screen_pkg.sv
package dst_screen_pkg;

  localparam int unsigned OCTET_W    = 8;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned HASH_IDX_W = 6;
  localparam int unsigned HASH_WORD  = 32;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_MULTICAST = 2'd1,
    CLS_BROADCAST = 2'd2
  } addr_class_e;

  // Fold one octet into the running CRC, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_octet(
    input logic [CRC_W-1:0]   crc_in,
    input logic [OCTET_W-1:0] octet,
    input logic [CRC_W-1:0]   poly
  );
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int i = 0; i < OCTET_W; i++) begin
      if (c[CRC_W-1] ^ octet[i]) c = {c[CRC_W-2:0], 1'b0} ^ poly;
      else                       c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction

  // Pick one bin from the two hash words; top index bit chooses the word.
  function automatic logic hash_pick(
    input logic [HASH_IDX_W-1:0] idx,
    input logic [HASH_WORD-1:0]  lo_word,
    input logic [HASH_WORD-1:0]  hi_word
  );
    logic [HASH_IDX_W-2:0] bit_sel;
    bit_sel = idx[HASH_IDX_W-2:0];
    return idx[HASH_IDX_W-1] ? hi_word[bit_sel] : lo_word[bit_sel];
  endfunction

  function automatic addr_class_e classify(input logic is_bcast, input logic is_mcast);
    if (is_bcast)      return CLS_BROADCAST;
    else if (is_mcast) return CLS_MULTICAST;
    else               return CLS_UNICAST;
  endfunction

  // Acceptance policy, in priority order.
  function automatic logic judge(
    input addr_class_e cls,
    input logic        promisc,
    input logic        bcast_reject,
    input logic        hash_unicast,
    input logic        station_hit,
    input logic        hash_bit
  );
    if (promisc) return 1'b1;
    case (cls)
      CLS_BROADCAST: return !bcast_reject;
      CLS_MULTICAST: return hash_bit;
      default:       return station_hit || (hash_unicast && hash_bit);
    endcase
  endfunction

endpackage

// File: rtl/dst_screen_seq.sv
module dst_screen_seq #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             byte_valid,
  output logic             take_byte,
  output logic [CNT_W-1:0] byte_pos,
  output logic             last_byte
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] taken_q;
  logic [CNT_W-1:0] taken_base;
  logic [CNT_W-1:0] taken_n;

  // A strobe restarts the count in the same cycle, so its octet is octet 0.
  assign taken_base = frame_start ? '0 : taken_q;
  assign take_byte  = byte_valid && (taken_base < CNT_FULL);
  assign byte_pos   = taken_base;
  assign last_byte  = take_byte && (taken_base == CNT_LAST);
  assign taken_n    = take_byte ? taken_base + 1'b1 : taken_base;

  // Reset to the full count: octets are ignored until the first strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken_q <= CNT_FULL;
    else        taken_q <= taken_n;
  end

endmodule

// File: rtl/dst_screen_crc.sv
module dst_screen_crc
  import dst_screen_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  take_byte,
  input  logic [OCTET_W-1:0]    byte_data,
  output logic [HASH_IDX_W-1:0] hash_idx
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_n;

  assign crc_base = restart ? CRC_SEED : crc_q;
  assign crc_n    = take_byte ? crc_fold_octet(crc_base, byte_data, CRC_POLY) : crc_base;
  // Index includes the octet taken this cycle, so it is ready with the last one.
  assign hash_idx = crc_n[CRC_W-1 -: HASH_IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_n;
  end

endmodule

// File: rtl/dst_screen_cmp.sv
module dst_screen_cmp
  import dst_screen_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               take_byte,
  input  logic [CNT_W-1:0]   byte_pos,
  input  logic [OCTET_W-1:0] byte_data,
  input  logic [ADDR_W-1:0]  station,
  output logic               match_now,
  output logic               bcast_now,
  output logic               mcast_now
);

  localparam logic [OCTET_W-1:0] ALL_ONES = '1;

  logic [ADDR_BYTES-1:0] lane_hit;
  logic match_q, bcast_q, mcast_q;
  logic match_base, bcast_base, mcast_base;

  // One comparator lane per octet position; octet 0 sits in the top bits.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    localparam int unsigned OFS = (ADDR_BYTES - 1 - g) * OCTET_W;
    assign lane_hit[g] = (byte_pos == CNT_W'(g)) && (byte_data == station[OFS +: OCTET_W]);
  end

  assign match_base = restart ? 1'b1 : match_q;
  assign bcast_base = restart ? 1'b1 : bcast_q;
  assign mcast_base = restart ? 1'b0 : mcast_q;

  always_comb begin
    match_now = match_base;
    bcast_now = bcast_base;
    mcast_now = mcast_base;
    if (take_byte) begin
      match_now = match_base && (|lane_hit);
      bcast_now = bcast_base && (byte_data == ALL_ONES);
      if (byte_pos == '0) mcast_now = byte_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else begin
      match_q <= match_now;
      bcast_q <= bcast_now;
      mcast_q <= mcast_now;
    end
  end

endmodule

// File: rtl/dst_screen_decide.sv
module dst_screen_decide
  import dst_screen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  last_byte,
  input  logic                  match_now,
  input  logic                  bcast_now,
  input  logic                  mcast_now,
  input  logic [HASH_IDX_W-1:0] hash_idx,
  input  logic [HASH_WORD-1:0]  hash_lo,
  input  logic [HASH_WORD-1:0]  hash_hi,
  input  logic                  cfg_promisc,
  input  logic                  cfg_bcast_reject,
  input  logic                  cfg_hash_unicast,
  output logic                  hash_hit,
  output logic                  decision_valid,
  output logic                  accept
);

  addr_class_e cls;
  logic        verdict;
  logic        valid_n;
  logic        accept_n;

  assign hash_hit = hash_pick(hash_idx, hash_lo, hash_hi);
  assign cls      = classify(bcast_now, mcast_now);
  assign verdict  = judge(cls, cfg_promisc, cfg_bcast_reject, cfg_hash_unicast,
                          match_now, hash_hit);

  always_comb begin
    valid_n  = restart ? 1'b0 : decision_valid;
    accept_n = restart ? 1'b0 : accept;
    if (last_byte) begin
      valid_n  = 1'b1;
      accept_n = verdict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision_valid <= 1'b0;
      accept         <= 1'b0;
    end else begin
      decision_valid <= valid_n;
      accept         <= accept_n;
    end
  end

endmodule

// File: rtl/dst_addr_screen.sv
module dst_addr_screen
  import dst_screen_pkg::*;
#(
  parameter int unsigned      ADDR_BYTES = 6,
  parameter logic [CRC_W-1:0] CRC_POLY   = 32'h04C11DB7,
  localparam int unsigned LO_W   = 4 * OCTET_W,
  localparam int unsigned HI_W   = (ADDR_BYTES - 4) * OCTET_W,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 byte_valid,
  input  logic [OCTET_W-1:0]   byte_data,
  input  logic [LO_W-1:0]      station_lo,
  input  logic [HI_W-1:0]      station_hi,
  input  logic [HASH_WORD-1:0] hash_lo,
  input  logic [HASH_WORD-1:0] hash_hi,
  input  logic                 cfg_promisc,
  input  logic                 cfg_bcast_reject,
  input  logic                 cfg_hash_unicast,
  output logic                 decision_valid,
  output logic                 accept
);

  // Named internal events, also observed by the bound checker.
  logic                  take_byte;
  logic [CNT_W-1:0]      byte_pos;
  logic                  last_byte_ev;
  logic [HASH_IDX_W-1:0] hash_idx;
  logic                  match_now;
  logic                  bcast_now;
  logic                  mcast_now;
  logic                  hash_hit;
  logic [ADDR_W-1:0]     station;

  assign station = {station_hi, station_lo};

  dst_screen_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .byte_valid  (byte_valid),
    .take_byte   (take_byte),
    .byte_pos    (byte_pos),
    .last_byte   (last_byte_ev)
  );

  dst_screen_crc #(.CRC_POLY(CRC_POLY)) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (frame_start),
    .take_byte (take_byte),
    .byte_data (byte_data),
    .hash_idx  (hash_idx)
  );

  dst_screen_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (frame_start),
    .take_byte (take_byte),
    .byte_pos  (byte_pos),
    .byte_data (byte_data),
    .station   (station),
    .match_now (match_now),
    .bcast_now (bcast_now),
    .mcast_now (mcast_now)
  );

  dst_screen_decide u_decide (
    .clk              (clk),
    .rst_n            (rst_n),
    .restart          (frame_start),
    .last_byte        (last_byte_ev),
    .match_now        (match_now),
    .bcast_now        (bcast_now),
    .mcast_now        (mcast_now),
    .hash_idx         (hash_idx),
    .hash_lo          (hash_lo),
    .hash_hi          (hash_hi),
    .cfg_promisc      (cfg_promisc),
    .cfg_bcast_reject (cfg_bcast_reject),
    .cfg_hash_unicast (cfg_hash_unicast),
    .hash_hit         (hash_hit),
    .decision_valid   (decision_valid),
    .accept           (accept)
  );

endmodule

// File: rtl/dst_screen_checker.sv
module dst_screen_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic byte_valid,
  input logic cfg_promisc,
  input logic cfg_bcast_reject,
  input logic last_byte_ev,
  input logic match_now,
  input logic bcast_now,
  input logic mcast_now,
  input logic hash_hit,
  input logic decision_valid,
  input logic accept
);

  assert_accept_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> decision_valid);

  assert_valid_follows_octet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_valid) |-> $past(byte_valid));

  assert_strobe_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !decision_valid);

  assert_verdict_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && !frame_start) |=> (decision_valid && $stable(accept)));

  assert_promisc_accepts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_ev && cfg_promisc) |=> accept);

  assert_bcast_policy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_ev && bcast_now && !cfg_promisc) |=> (accept == !$past(cfg_bcast_reject)));

  assert_station_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_ev && match_now && !mcast_now && !cfg_promisc) |=> accept);

  assert_mcast_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte_ev && mcast_now && !bcast_now && !cfg_promisc) |=> (accept == $past(hash_hit)));

endmodule

bind dst_addr_screen dst_screen_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .frame_start      (frame_start),
  .byte_valid       (byte_valid),
  .cfg_promisc      (cfg_promisc),
  .cfg_bcast_reject (cfg_bcast_reject),
  .last_byte_ev     (last_byte_ev),
  .match_now        (match_now),
  .bcast_now        (bcast_now),
  .mcast_now        (mcast_now),
  .hash_hit         (hash_hit),
  .decision_valid   (decision_valid),
  .accept           (accept)
);

// File: tb/dst_addr_screen_bench.sv
`timescale 1ns/1ps
module dst_addr_screen_bench;

  localparam logic [47:0] STATION = 48'h0211_2233_4455;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam int unsigned NVEC = 13;

  // {address, promisc, bcast_reject, hash_unicast, program_bin, expected}
  localparam logic [52:0] VEC [NVEC] = '{
    {48'h0211_2233_4455, 5'b000_0_1},  // R4 station match
    {48'h0211_2233_4456, 5'b000_1_0},  // R7 miss, hash bin ignored
    {48'h0211_2233_4456, 5'b001_1_1},  // R7 hash unicast, bin set
    {48'h0211_2233_4456, 5'b001_0_0},  // R7 hash unicast, bin clear
    {48'h0100_5E00_0001, 5'b000_1_1},  // R6 multicast bin set
    {48'h0100_5E00_0001, 5'b000_0_0},  // R6 multicast bin clear
    {48'hFFFF_FFFF_FFFF, 5'b000_0_1},  // R5 broadcast allowed
    {48'hFFFF_FFFF_FFFF, 5'b010_1_0},  // R5 broadcast rejected
    {48'h0211_2233_4456, 5'b100_0_1},  // R8 promiscuous unicast
    {48'hFFFF_FFFF_FFFF, 5'b110_0_1},  // R8 promiscuous over reject
    {48'h0211_2233_4455, 5'b001_0_1},  // R4 match wins over clear bin
    {48'h0311_2233_4455, 5'b000_0_0},  // R6 multicast bit alone
    {48'h0211_2333_4455, 5'b000_1_0}   // R4 octet 2 differs
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [31:0] station_lo;
  logic [15:0] station_hi;
  logic [31:0] hash_lo = '0;
  logic [31:0] hash_hi = '0;
  logic        cfg_promisc = 1'b0;
  logic        cfg_bcast_reject = 1'b0;
  logic        cfg_hash_unicast = 1'b0;
  logic        decision_valid;
  logic        accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dst_addr_screen u_dst_addr_screen (
    .clk              (clk),
    .rst_n            (rst_n),
    .frame_start      (frame_start),
    .byte_valid       (byte_valid),
    .byte_data        (byte_data),
    .station_lo       (station_lo),
    .station_hi       (station_hi),
    .hash_lo          (hash_lo),
    .hash_hi          (hash_hi),
    .cfg_promisc      (cfg_promisc),
    .cfg_bcast_reject (cfg_bcast_reject),
    .cfg_hash_unicast (cfg_hash_unicast),
    .decision_valid   (decision_valid),
    .accept           (accept)
  );

  // Hash bin from the stated CRC rules, written as a shift with masked feedback.
  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] r;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 8; j++) begin
        fb = r[31] ^ a[40 - 8*k + j];
        r  = {r[30:0], 1'b0} ^ ({32{fb}} & 32'h04C11DB7);
      end
    end
    return r[31:26];
  endfunction

  task automatic check(input string req, input logic actual, input logic expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, actual, expected);
    end
  endtask

  task automatic drive(input logic st, input logic v, input logic [7:0] d);
    @(posedge clk); #1;
    frame_start = st;
    byte_valid  = v;
    byte_data   = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 8'h00);
  endtask

  task automatic send_octets(input logic [47:0] a, input int first, input int last);
    for (int k = first; k <= last; k++) drive(1'b0, 1'b1, a[47 - 8*k -: 8]);
  endtask

  task automatic send_addr(input logic [47:0] a);
    drive(1'b1, 1'b0, 8'h00);
    send_octets(a, 0, 5);
    idle();
  endtask

  task automatic program_hash(input logic [5:0] bin, input logic set_only);
    logic [63:0] h;
    h = 64'd1 << bin;
    if (!set_only) h = ~h;
    hash_hi = h[63:32];
    hash_lo = h[31:0];
  endtask

  initial begin
    station_hi = STATION[47:32];
    station_lo = STATION[31:0];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", decision_valid, 1'b0);
    check("R1 accept after reset", accept, 1'b0);
    rst_n = 1'b1;

    // R3: octets before any strobe are ignored
    send_octets(STATION, 0, 5);
    idle();
    @(negedge clk);
    check("R3 no strobe yet", decision_valid, 1'b0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] a;
      a = VEC[i][52:5];
      cfg_promisc      = VEC[i][4];
      cfg_bcast_reject = VEC[i][3];
      cfg_hash_unicast = VEC[i][2];
      program_hash(ref_bin(a), VEC[i][1]);
      send_addr(a);
      @(negedge clk);
      check($sformatf("R2 vec %0d valid", i), decision_valid, 1'b1);
      check($sformatf("R4-R8 vec %0d accept", i), accept, VEC[i][0]);
    end
    cfg_promisc = 1'b0; cfg_bcast_reject = 1'b0; cfg_hash_unicast = 1'b0;
    program_hash(6'd0, 1'b0);

    // R2: gaps between octets; not valid before the sixth
    drive(1'b1, 1'b0, 8'h00);
    send_octets(STATION, 0, 2);
    idle(); idle();
    send_octets(STATION, 3, 4);
    idle();
    @(negedge clk);
    check("R2 five octets", decision_valid, 1'b0);
    check("R10 accept gated", accept, 1'b0);
    send_octets(STATION, 5, 5);
    idle();
    @(negedge clk);
    check("R2 sixth octet", decision_valid, 1'b1);
    check("R2 gapped accept", accept, 1'b1);

    // R9: extra octets and config changes leave the verdict alone
    station_lo = 32'h0;
    cfg_hash_unicast = 1'b1;
    hash_lo = '0; hash_hi = '0;
    send_octets(BCAST, 0, 5);
    idle();
    @(negedge clk);
    check("R9 held valid", decision_valid, 1'b1);
    check("R9 held accept", accept, 1'b1);
    station_lo = STATION[31:0];
    cfg_hash_unicast = 1'b0;
    program_hash(6'd0, 1'b0);

    // R3: strobe alone clears the verdict
    drive(1'b1, 1'b0, 8'h00);
    idle();
    @(negedge clk);
    check("R3 strobe clears", decision_valid, 1'b0);
    check("R10 cleared accept", accept, 1'b0);

    // R3: strobe mid-address discards partial broadcast
    cfg_bcast_reject = 1'b1;
    drive(1'b1, 1'b0, 8'h00);
    send_octets(BCAST, 0, 2);
    drive(1'b1, 1'b0, 8'h00);
    send_octets(STATION, 0, 5);
    idle();
    @(negedge clk);
    check("R3 restart valid", decision_valid, 1'b1);
    check("R3 restart accept", accept, 1'b1);
    cfg_bcast_reject = 1'b0;

    // R3: octet on the strobe cycle is octet 0
    drive(1'b1, 1'b1, STATION[47:40]);
    send_octets(STATION, 1, 5);
    idle();
    @(negedge clk);
    check("R3 strobe octet valid", decision_valid, 1'b1);
    check("R3 strobe octet accept", accept, 1'b1);

    // R7: mismatch in octet 0 only (unicast), hash off
    send_addr(48'h0011_2233_4455);
    @(negedge clk);
    check("R7 octet0 miss", accept, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule